// File: doc/BRIEF.md
# Bidirectional GPIO Port Register Block

This block is an eight-bit general-purpose I/O port that is programmed over a synchronous register bus. Each pin bit has a direction bit and an output latch bit. It also has an input path, and that path crosses into the clock domain through a two-flop synchroniser. Software sets the direction of each pin. It writes the value to drive into the output latch. It reads either the latch or the real pin levels, and it picks between them by address.

Because the latch and the pin levels come back at separate addresses, a read-modify-write sequence that works on the latch address uses the intended output value. A pin held low by an external load does not corrupt it. For any pin whose alternate-function enable is set, a peripheral takes that pin over: the peripheral supplies both the driven value and the output enable. The latch and the direction register stay untouched while it does.

Top module: `gpio_port_top`

## Requirements
- R1: After reset the direction register reads 0xFF (every pin an input), the output latch reads 0x00, `pinOe` is 0x00 and `regRdData` is 0x00.
- R2: A write to address 0 loads the direction register on that clock edge, and a read of address 0 returns the stored value.
- R3: A write to address 2 loads the output latch, and a read of address 2 returns the latch contents whatever the pin levels are.
- R4: A write to address 1 also loads the output latch, which is the same storage that address 2 writes.
- R5: A read of address 1 returns the synchronised pin levels. It does not return the latch value.
- R6: For a bit whose alternate-function enable is low, `pinOe` is the inverse of the direction bit (direction 1 = input, driver off), and `pinOut` is the latch bit.
- R7: For a bit whose alternate-function enable is high, `pinOut` and `pinOe` take `altOut` and `altOe`, and the latch and direction contents stay unchanged.
- R8: Read data is registered. It updates on the edge where `regRdEn` is sampled high and holds its value while `regRdEn` is low.
- R9: When a read and a write to the latch address fall in the same cycle, the read returns the latch value from before the write.
- R10: Address 3 is reserved. Reads of it return 0x00, and writes to it change no register.
- R11: A pin change first shows in a pin-level read on the third read edge after the change: the synchroniser adds two clocks, and the read register adds one more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 2 | Register address (0 direction, 1 pin level, 2 latch, 3 reserved) |
| regWrEn | input | 1 | Write enable |
| regRdEn | input | 1 | Read enable |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Registered read data |
| pinIn | input | 8 | Pin input levels (asynchronous) |
| pinOut | output | 8 | Pin output values |
| pinOe | output | 8 | Pin output enables, 1 = driver on |
| altEn | input | 8 | Per-bit alternate-function enable |
| altOut | input | 8 | Peripheral output values |
| altOe | input | 8 | Peripheral output enables |

## Verification
The hardest condition to reach from the ports is the synchroniser window. A pin-level read has to land in the cycles where the new pin value is inside the flop chain but has not yet reached the read mux. The stimulus changes `pinIn` and holds `regRdEn` high for three consecutive edges in the same cycle. It expects the old, old and new values in that order. A second hard case is a read and a write to the latch in one cycle. The bench drives both enables together and expects the pre-write value, then the new value on a following read.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_DIR  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_PIN  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_LAT  = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_RSVD = 2'd3;

  typedef enum logic [1:0] {
    SEL_DIR  = 2'd0,
    SEL_PIN  = 2'd1,
    SEL_LAT  = 2'd2,
    SEL_NONE = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic   wrDir;
    logic   wrLatch;
    logic   rdStb;
    rdSel_e rdSel;
  } portStrobe_t;

endpackage

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic              regRdEn,
  output portStrobe_t       strobe
);

  always_comb begin
    strobe.wrDir   = 1'b0;
    strobe.wrLatch = 1'b0;
    strobe.rdStb   = regRdEn;
    strobe.rdSel   = SEL_NONE;
    unique case (regAddr)
      ADDR_DIR: begin
        strobe.wrDir = regWrEn;
        strobe.rdSel = SEL_DIR;
      end
      ADDR_PIN: begin
        strobe.wrLatch = regWrEn;   // pin address writes go to the latch
        strobe.rdSel   = SEL_PIN;
      end
      ADDR_LAT: begin
        strobe.wrLatch = regWrEn;
        strobe.rdSel   = SEL_LAT;
      end
      default: strobe.rdSel = SEL_NONE;
    endcase
  end

  p_single_write_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.wrDir, strobe.wrLatch}));

  p_reserved_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_RSVD) |-> (!strobe.wrDir && !strobe.wrLatch));

endmodule

// File: rtl/gpio_port_datapath.sv
module gpio_port_datapath
  import gpio_port_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  portStrobe_t      strobe,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] rdData,
  input  logic [WIDTH-1:0] pinIn,
  output logic [WIDTH-1:0] pinOut,
  output logic [WIDTH-1:0] pinOe,
  input  logic [WIDTH-1:0] altEn,
  input  logic [WIDTH-1:0] altOut,
  input  logic [WIDTH-1:0] altOe
);

  localparam logic [WIDTH-1:0] DIR_RESET = {WIDTH{1'b1}};
  localparam int LAST = SYNC_STAGES - 1;

  logic [WIDTH-1:0] dirReg;
  logic [WIDTH-1:0] latchReg;
  logic [SYNC_STAGES-1:0][WIDTH-1:0] syncChain;
  logic [WIDTH-1:0] pinLevel;
  logic [WIDTH-1:0] rdMux;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirReg   <= DIR_RESET;
      latchReg <= '0;
    end else begin
      if (strobe.wrDir)   dirReg   <= wrData;
      if (strobe.wrLatch) latchReg <= wrData;
    end
  end

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)       syncChain[s] <= '0;
        else if (s == 0) syncChain[s] <= pinIn;
        else             syncChain[s] <= syncChain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign pinLevel = syncChain[LAST];

  always_comb begin
    unique case (strobe.rdSel)
      SEL_DIR:  rdMux = dirReg;
      SEL_PIN:  rdMux = pinLevel;
      SEL_LAT:  rdMux = latchReg;
      default:  rdMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             rdData <= '0;
    else if (strobe.rdStb) rdData <= rdMux;
  end

  generate
    for (genvar b = 0; b < WIDTH; b++) begin : g_pad
      assign pinOut[b] = altEn[b] ? altOut[b] : latchReg[b];
      assign pinOe[b]  = altEn[b] ? altOe[b]  : ~dirReg[b];
    end
  endgenerate

  p_dir_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrDir |=> (dirReg == $past(wrData)));

  p_latch_load_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrLatch |=> (latchReg == $past(wrData)));

  p_rd_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.rdStb |=> $stable(rdData));

  p_latch_keep_r7: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.wrLatch |=> $stable(latchReg));

endmodule

// File: rtl/gpio_port_top.sv
module gpio_port_top
  import gpio_port_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [WIDTH-1:0]  regWrData,
  output logic [WIDTH-1:0]  regRdData,
  input  logic [WIDTH-1:0]  pinIn,
  output logic [WIDTH-1:0]  pinOut,
  output logic [WIDTH-1:0]  pinOe,
  input  logic [WIDTH-1:0]  altEn,
  input  logic [WIDTH-1:0]  altOut,
  input  logic [WIDTH-1:0]  altOe
);

  portStrobe_t strobe;

  gpio_port_ctrl i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .regAddr (regAddr),
    .regWrEn (regWrEn),
    .regRdEn (regRdEn),
    .strobe  (strobe)
  );

  gpio_port_datapath #(
    .WIDTH       (WIDTH),
    .SYNC_STAGES (SYNC_STAGES)
  ) i_datapath (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .wrData (regWrData),
    .rdData (regRdData),
    .pinIn  (pinIn),
    .pinOut (pinOut),
    .pinOe  (pinOe),
    .altEn  (altEn),
    .altOut (altOut),
    .altOe  (altOe)
  );

endmodule

// File: tb/test_gpio_port_top.sv
module test_gpio_port_top;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] regAddr = '0;
  logic       regWrEn = 1'b0;
  logic       regRdEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic [7:0] pinIn = '0;
  logic [7:0] pinOut;
  logic [7:0] pinOe;
  logic [7:0] altEn = '0;
  logic [7:0] altOut = '0;
  logic [7:0] altOe = '0;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [7:0] expQ[$];
  string      tagQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_port_top i_gpio_port_top (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regRdEn(regRdEn), .regWrData(regWrData), .regRdData(regRdData),
    .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe),
    .altEn(altEn), .altOut(altOut), .altOe(altOe)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: a read sampled at a posedge is compared at the following negedge.
  initial begin
    forever begin
      logic rdSeen;
      @(posedge clk);
      rdSeen = regRdEn && rstN;
      @(negedge clk);
      if (rdSeen) begin
        if (expQ.size() == 0) begin
          checks++; failures++;
          $display("FAIL scoreboard unexpected read actual=%h expected=none", regRdData);
        end else begin
          logic [7:0] e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          check(t, regRdData, e);
        end
      end
    end
  end

  task automatic doWrite(input logic [1:0] a, input logic [7:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic doRead(input logic [1:0] a, input logic [7:0] exp, input string tag);
    expQ.push_back(exp); tagQ.push_back(tag);
    regAddr = a; regRdEn = 1'b1;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 pinOe", pinOe, 8'h00);
    check("R1 rdData", regRdData, 8'h00);
    check("R1 pinOut", pinOut, 8'h00);
    doRead(2'd0, 8'hFF, "R1 dir reset");
    doRead(2'd2, 8'h00, "R1 latch reset");

    // R2 direction write/readback, R6 output enable
    doWrite(2'd0, 8'h0F);
    doRead(2'd0, 8'h0F, "R2 dir readback");
    check("R6 pinOe from dir", pinOe, 8'hF0);

    // R3 latch write/readback
    doWrite(2'd2, 8'hA5);
    doRead(2'd2, 8'hA5, "R3 latch readback");
    check("R6 pinOut from latch", pinOut, 8'hA5);

    // R4 pin address write lands in latch
    doWrite(2'd1, 8'h3C);
    doRead(2'd2, 8'h3C, "R4 latch via pin addr");
    check("R4 pinOut", pinOut, 8'h3C);

    // R5 pin level read, not latch
    pinIn = 8'h81;
    repeat (3) @(negedge clk);
    doRead(2'd1, 8'h81, "R5 pin level 81");
    doRead(2'd2, 8'h3C, "R5 latch unchanged");
    pinIn = 8'h5A;
    repeat (3) @(negedge clk);
    doRead(2'd1, 8'h5A, "R5 pin level 5A");

    // R11 synchroniser latency: three back-to-back reads
    pinIn = 8'hC3;
    expQ.push_back(8'h5A); tagQ.push_back("R11 read edge 1");
    expQ.push_back(8'h5A); tagQ.push_back("R11 read edge 2");
    expQ.push_back(8'hC3); tagQ.push_back("R11 read edge 3");
    regAddr = 2'd1; regRdEn = 1'b1;
    repeat (3) @(negedge clk);
    regRdEn = 1'b0;

    // R8 hold while rdEn low
    pinIn = 8'h00;
    repeat (4) @(negedge clk);
    check("R8 rdData held", regRdData, 8'hC3);

    // R9 simultaneous read and write of latch
    expQ.push_back(8'h3C); tagQ.push_back("R9 read before write");
    regAddr = 2'd2; regWrData = 8'h77; regWrEn = 1'b1; regRdEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; regRdEn = 1'b0;
    doRead(2'd2, 8'h77, "R9 new latch value");

    // R10 reserved address
    doWrite(2'd3, 8'hFF);
    doRead(2'd3, 8'h00, "R10 reserved reads zero");
    doRead(2'd0, 8'h0F, "R10 dir untouched");
    doRead(2'd2, 8'h77, "R10 latch untouched");

    // R7 alternate override
    altEn = 8'h81; altOut = 8'h80; altOe = 8'h01;
    #1;
    check("R7 pinOut override", pinOut, 8'hF6);
    check("R7 pinOe override", pinOe, 8'h71);
    doRead(2'd2, 8'h77, "R7 latch kept");
    doRead(2'd0, 8'h0F, "R7 dir kept");
    altEn = 8'h00;
    #1;
    check("R6 pinOut restored", pinOut, 8'h77);

    repeat (2) @(negedge clk);
    if (expQ.size() != 0) begin
      checks++; failures++;
      $display("FAIL scoreboard leftover actual=%0d expected=0", expQ.size());
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule